// File: doc/BRIEF.md
# Reference Clock Selector with Controller Clock Failover

This block chooses between an internal and an external timebase reference and derives a slower controller clock from whichever one is chosen. An activity detector, timed by the internal reference, watches the external input. Once the external input has toggled steadily for a short time it is taken as the reference. Once it has been quiet for a fixed time the internal reference is taken back. Every handover between the two references goes through a gated multiplexer with a handshake, so the selected reference never carries a runt pulse.

The selected reference is divided by five, with a duty cycle near 50%, to give the controller clock. A watchdog runs from a free-running local oscillator and watches the divided clock. If the selected reference stops altogether, the controller clock moves to the oscillator without a glitch and a failure flag is raised. When the reference runs again, the controller clock moves back to the divided reference. Both status flags are retimed into the controller clock domain.

Top module: `refclk_failover`

## Requirements
- R1: While rst_n is low, ref_out, ctl_clk, ext_selected and clk_failed are all 0. After reset, with the external input idle, the internal reference drives ref_out and ext_selected is 0.
- R2: When the external input toggles with at least 8 rising edges seen inside one 16-cycle window of the internal reference, ext_selected becomes 1 and ref_out follows the external input.
- R3: When no external edge is seen for 40 consecutive internal-reference cycles (4 us at 10 MHz), ext_selected returns to 0 and ref_out follows the internal reference again.
- R4: A pause in the external input shorter than the absence window leaves ext_selected at 1 and ref_out on the external input.
- R5: ref_out never carries a high or low pulse shorter than half a period of the faster reference, across every handover. The two reference enables are never active together.
- R6: ctl_clk has a period of five ref_out periods and stays high for two and a half of them.
- R7: If ref_out stops for 64 fallback-oscillator cycles, clk_failed becomes 1 and ctl_clk follows clk_osc.
- R8: After ref_out has resumed and four divided-clock periods have been seen, clk_failed returns to 0 and ctl_clk is again ref_out divided by five.
- R9: ctl_clk never carries a pulse shorter than half a clk_osc period, and the divided and fallback paths are never enabled together.
- R10: ext_selected and clk_failed change only on a rising edge of ctl_clk.
- R11: Losing the external reference while it is selected does not raise clk_failed, because the return to the internal reference completes inside the watchdog window.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_int | input | 1 | Internal reference clock, nominally 10 MHz |
| clk_ext | input | 1 | External reference clock input, may be absent |
| clk_osc | input | 1 | Free-running local fallback oscillator |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_out | output | 1 | Selected reference clock |
| ctl_clk | output | 1 | Controller clock: ref_out divided by five, or the fallback oscillator |
| ext_selected | output | 1 | 1 while the external reference is selected, retimed to ctl_clk |
| clk_failed | output | 1 | 1 while the controller clock runs from the fallback, retimed to ctl_clk |

## Verification
A stuck or miscounted detector counter shows up as a wrong value on ext_selected and a wrong ref_out period a few microseconds after the external input starts or stops. A wrong divider state shows up in the first ctl_clk period that is measured, as a wrong period or high time. A broken enable handshake shows up as a short pulse on ref_out or ctl_clk at the very next handover. A watchdog that trips too early shows up as a spurious clk_failed rise during the external-loss handover. A watchdog that never trips leaves ctl_clk dead once the reference stops.

// File: rtl/refclk_failover.sv
module refclk_failover #(
  parameter int DIV           = 5,
  parameter int PRESENT_EDGES = 8,
  parameter int PRESENT_WIN   = 16,
  parameter int ABSENT_CYC    = 40,
  parameter int WD_CYC        = 64,
  parameter int RECOVER_EDGES = 4
) (
  input  logic clk_int,
  input  logic clk_ext,
  input  logic clk_osc,
  input  logic rst_n,
  output logic ref_out,
  output logic ctl_clk,
  output logic ext_selected,
  output logic clk_failed
);

  localparam int DW = $clog2(DIV);
  localparam int WW = $clog2(PRESENT_WIN);
  localparam int EW = $clog2(PRESENT_EDGES);
  localparam int AW = $clog2(ABSENT_CYC);
  localparam int GW = $clog2(WD_CYC);
  localparam int RW = $clog2(RECOVER_EDGES);

  localparam logic [DW-1:0] CNT_LAST  = DW'(DIV - 1);
  localparam logic [DW-1:0] HI_CNT    = DW'(DIV / 2);
  localparam logic [WW-1:0] WIN_LAST  = WW'(PRESENT_WIN - 1);
  localparam logic [EW-1:0] EDGE_LAST = EW'(PRESENT_EDGES - 1);
  localparam logic [AW-1:0] IDLE_LAST = AW'(ABSENT_CYC - 1);
  localparam logic [GW-1:0] GAP_LAST  = GW'(WD_CYC - 1);
  localparam logic [RW-1:0] GOOD_LAST = RW'(RECOVER_EDGES - 1);

  // external activity: toggle in its own domain, edge-detected in the internal domain
  logic ext_tog;
  always_ff @(posedge clk_ext or negedge rst_n)
    if (!rst_n) ext_tog <= 1'b0;
    else        ext_tog <= ~ext_tog;

  logic [2:0] ext_sy;
  logic       ext_edge;
  always_ff @(posedge clk_int or negedge rst_n)
    if (!rst_n) ext_sy <= '0;
    else        ext_sy <= {ext_sy[1:0], ext_tog};
  assign ext_edge = ext_sy[2] ^ ext_sy[1];

  logic [WW-1:0] win_cnt;
  logic [EW-1:0] edge_cnt;
  logic [AW-1:0] idle_cnt;
  logic          sel;

  always_ff @(posedge clk_int or negedge rst_n)
    if (!rst_n) begin
      win_cnt  <= '0;
      edge_cnt <= '0;
      idle_cnt <= '0;
      sel      <= 1'b0;
    end else begin
      win_cnt <= (win_cnt == WIN_LAST) ? '0 : win_cnt + 1'b1;
      if (win_cnt == WIN_LAST)
        edge_cnt <= {{(EW-1){1'b0}}, ext_edge};
      else if (ext_edge && edge_cnt != EDGE_LAST)
        edge_cnt <= edge_cnt + 1'b1;
      if (ext_edge)
        idle_cnt <= '0;
      else if (idle_cnt != IDLE_LAST)
        idle_cnt <= idle_cnt + 1'b1;
      if (ext_edge && edge_cnt == EDGE_LAST)
        sel <= 1'b1;
      else if (!ext_edge && idle_cnt == IDLE_LAST)
        sel <= 1'b0;
    end

  // reference mux: each side enables on its own falling edge after the other side has let go
  logic ia, ib, xa, xb;
  logic ext_arst_n;
  assign ext_arst_n = rst_n & sel;

  always_ff @(posedge clk_int or negedge rst_n)
    if (!rst_n) ia <= 1'b0;
    else        ia <= ~sel & ~xb;
  always_ff @(negedge clk_int or negedge rst_n)
    if (!rst_n) ib <= 1'b0;
    else        ib <= ia;

  always_ff @(posedge clk_ext or negedge ext_arst_n)
    if (!ext_arst_n) xa <= 1'b0;
    else             xa <= ~ib;
  always_ff @(negedge clk_ext or negedge ext_arst_n)
    if (!ext_arst_n) xb <= 1'b0;
    else             xb <= xa;

  assign ref_out = (clk_int & ib) | (clk_ext & xb);

  // divide by DIV, rising-edge phase ORed with a half-cycle delayed copy
  logic [DW-1:0] dcnt, dnxt;
  logic          dp, dn, wd_tog;
  logic          div_clk;
  assign dnxt = (dcnt == CNT_LAST) ? '0 : dcnt + 1'b1;

  always_ff @(posedge ref_out or negedge rst_n)
    if (!rst_n) begin
      dcnt   <= '0;
      dp     <= 1'b0;
      wd_tog <= 1'b0;
    end else begin
      dcnt <= dnxt;
      dp   <= dnxt < HI_CNT;
      if (dcnt == CNT_LAST) wd_tog <= ~wd_tog;
    end

  always_ff @(negedge ref_out or negedge rst_n)
    if (!rst_n) dn <= 1'b0;
    else        dn <= dp;

  assign div_clk = dp | dn;

  // watchdog in the fallback oscillator domain
  logic [2:0]    wd_sy;
  logic          wd_edge;
  logic [GW-1:0] gap_cnt;
  logic [RW-1:0] good_cnt;
  logic          failed;

  always_ff @(posedge clk_osc or negedge rst_n)
    if (!rst_n) wd_sy <= '0;
    else        wd_sy <= {wd_sy[1:0], wd_tog};
  assign wd_edge = wd_sy[2] ^ wd_sy[1];

  always_ff @(posedge clk_osc or negedge rst_n)
    if (!rst_n) begin
      gap_cnt  <= '0;
      good_cnt <= '0;
      failed   <= 1'b0;
    end else if (wd_edge) begin
      gap_cnt <= '0;
      if (failed) begin
        if (good_cnt == GOOD_LAST) begin
          failed   <= 1'b0;
          good_cnt <= '0;
        end else begin
          good_cnt <= good_cnt + 1'b1;
        end
      end
    end else if (gap_cnt == GAP_LAST) begin
      failed   <= 1'b1;
      good_cnt <= '0;
    end else begin
      gap_cnt <= gap_cnt + 1'b1;
    end

  // controller clock mux: divided reference versus fallback oscillator
  logic aa, ab, ba, bb;
  logic div_arst_n;
  assign div_arst_n = rst_n & ~failed;

  always_ff @(posedge div_clk or negedge div_arst_n)
    if (!div_arst_n) aa <= 1'b0;
    else             aa <= ~bb;
  always_ff @(negedge div_clk or negedge div_arst_n)
    if (!div_arst_n) ab <= 1'b0;
    else             ab <= aa;

  always_ff @(posedge clk_osc or negedge rst_n)
    if (!rst_n) ba <= 1'b0;
    else        ba <= failed & ~ab;
  always_ff @(negedge clk_osc or negedge rst_n)
    if (!rst_n) bb <= 1'b0;
    else        bb <= ba;

  assign ctl_clk = (div_clk & ab) | (clk_osc & bb);

  // status retimed to the controller clock
  logic [1:0] es_q, fs_q;
  always_ff @(posedge ctl_clk or negedge rst_n)
    if (!rst_n) begin
      es_q <= '0;
      fs_q <= '0;
    end else begin
      es_q <= {es_q[0], sel};
      fs_q <= {fs_q[0], failed};
    end

  assign ext_selected = es_q[1];
  assign clk_failed   = fs_q[1];

endmodule

// File: rtl/refclk_failover_chk.sv
module refclk_failover_chk (
  input logic clk_int,
  input logic clk_osc,
  input logic rst_n,
  input logic sel,
  input logic ext_edge,
  input logic ib,
  input logic xb,
  input logic ab,
  input logic bb,
  input logic failed
);

  always_comb
    if (rst_n)
      a_r5_one_ref_enable: assert ($onehot0({ib, xb}))
        else $error("R5: both reference enables active");

  always_comb
    if (rst_n)
      a_r9_one_ctl_enable: assert ($onehot0({ab, bb}))
        else $error("R9: divided and fallback paths both enabled");

  a_r2_select_on_edge: assert property (@(posedge clk_int) disable iff (!rst_n)
    $rose(sel) |-> $past(ext_edge))
    else $error("R2: external selected without an observed edge");

  a_r3_release_when_quiet: assert property (@(posedge clk_int) disable iff (!rst_n)
    $fell(sel) |-> !$past(ext_edge))
    else $error("R3: external released while an edge was seen");

  a_r7_fallback_needs_fail: assert property (@(posedge clk_osc) disable iff (!rst_n)
    $rose(bb) |-> $past(failed))
    else $error("R7: fallback enabled without a failure");

endmodule

bind refclk_failover refclk_failover_chk u_chk (
  .clk_int (clk_int),
  .clk_osc (clk_osc),
  .rst_n   (rst_n),
  .sel     (sel),
  .ext_edge(ext_edge),
  .ib      (ib),
  .xb      (xb),
  .ab      (ab),
  .bb      (bb),
  .failed  (failed)
);

// File: tb/sim_refclk_failover.sv
module sim_refclk_failover;
  localparam int CLK_PERIOD = 100;
  localparam int EXT_PERIOD = 96;
  localparam int OSC_PERIOD = 130;

  logic clk_int = 1'b0, clk_ext = 1'b0, clk_osc = 1'b0, rst_n = 1'b0;
  logic int_run = 1'b1, ext_run = 1'b0;
  logic ref_out, ctl_clk, ext_selected, clk_failed;

  refclk_failover u0 (
    .clk_int(clk_int), .clk_ext(clk_ext), .clk_osc(clk_osc), .rst_n(rst_n),
    .ref_out(ref_out), .ctl_clk(ctl_clk),
    .ext_selected(ext_selected), .clk_failed(clk_failed)
  );

  always #(CLK_PERIOD/2) clk_int = int_run ? ~clk_int : clk_int;
  always #(EXT_PERIOD/2) clk_ext = ext_run ? ~clk_ext : clk_ext;
  always #(OSC_PERIOD/2) clk_osc = ~clk_osc;

  int n_chk = 0, n_fail = 0;
  int glitch_r = 0, glitch_c = 0, fail_rises = 0;
  bit mon_en = 1'b0;
  time last_r = 0, last_c = 0;

  typedef struct packed {
    logic ext;
    logic fail;
    int   cper;
    int   chi;
    int   rper;
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];
  event  go_ev, done_ev;

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, expv);
    end
  endtask

  task automatic expect_state(input string tag, input bit ext, input bit fail,
                              input int cper, input int chi, input int rper);
    exp_t e;
    e.ext = ext; e.fail = fail; e.cper = cper; e.chi = chi; e.rper = rper;
    exp_q.push_back(e);
    tag_q.push_back(tag);
    -> go_ev;
    @(done_ev);
  endtask

  // monitor: pops expectations and measures the outputs
  initial begin
    forever begin
      @(go_ev);
      while (exp_q.size() > 0) begin
        exp_t e;
        string tg;
        time t0, t1, t2, r0, r1;
        e  = exp_q[0];
        tg = tag_q[0];
        @(posedge ctl_clk); t0 = $time;
        @(negedge ctl_clk); t1 = $time;
        @(posedge ctl_clk); t2 = $time;
        chk(longint'(t2 - t0) == e.cper, tg, "ctl_clk period", longint'(t2 - t0), e.cper);
        chk(longint'(t1 - t0) == e.chi,  tg, "ctl_clk high",   longint'(t1 - t0), e.chi);
        if (e.rper != 0) begin
          @(posedge ref_out); r0 = $time;
          @(posedge ref_out); r1 = $time;
          chk(longint'(r1 - r0) == e.rper, tg, "ref_out period", longint'(r1 - r0), e.rper);
        end
        #1;
        chk(ext_selected == e.ext, tg, "ext_selected", longint'(ext_selected), longint'(e.ext));
        chk(clk_failed == e.fail,  tg, "clk_failed",   longint'(clk_failed),   longint'(e.fail));
        exp_q.pop_front();
        tag_q.pop_front();
      end
      -> done_ev;
    end
  end

  // R5 / R9 pulse-width monitors
  always @(ref_out) begin
    if (mon_en && ($time - last_r) < 40) glitch_r++;
    last_r = $time;
  end
  always @(ctl_clk) begin
    if (mon_en && ($time - last_c) < 60) glitch_c++;
    last_c = $time;
  end
  always @(posedge clk_failed) if (rst_n) fail_rises++;

  // R10: status moves only with a ctl_clk rising edge
  always @(ext_selected or clk_failed)
    if (rst_n) chk(ctl_clk === 1'b1, "R10", "ctl_clk at status change", longint'(ctl_clk), 1);

  task automatic finish_run;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #(20000 * CLK_PERIOD);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=0", n_chk);
    finish_run();
  end

  initial begin
    #(5 * CLK_PERIOD + 7);
    chk(ref_out == 1'b0,      "R1", "ref_out in reset",      longint'(ref_out), 0);
    chk(ctl_clk == 1'b0,      "R1", "ctl_clk in reset",      longint'(ctl_clk), 0);
    chk(ext_selected == 1'b0, "R1", "ext_selected in reset", longint'(ext_selected), 0);
    chk(clk_failed == 1'b0,   "R1", "clk_failed in reset",   longint'(clk_failed), 0);
    #(5 * CLK_PERIOD);
    rst_n = 1'b1;
    #(30 * CLK_PERIOD);
    mon_en = 1'b1;
    expect_state("R1 R6 internal", 1'b0, 1'b0, 500, 250, 100);

    ext_run = 1'b1;
    #(60 * CLK_PERIOD);
    expect_state("R2 R6 external", 1'b1, 1'b0, 480, 240, 96);

    ext_run = 1'b0;
    #(15 * CLK_PERIOD);
    ext_run = 1'b1;
    #(30 * CLK_PERIOD);
    expect_state("R4 short pause", 1'b1, 1'b0, 480, 240, 96);

    ext_run = 1'b0;
    #(100 * CLK_PERIOD);
    expect_state("R3 back to internal", 1'b0, 1'b0, 500, 250, 100);
    chk(fail_rises == 0, "R11", "clk_failed rises", fail_rises, 0);

    int_run = 1'b0;
    #(200 * CLK_PERIOD);
    expect_state("R7 fallback", 1'b0, 1'b1, OSC_PERIOD, OSC_PERIOD/2, 0);

    int_run = 1'b1;
    #(80 * CLK_PERIOD);
    expect_state("R8 recovered", 1'b0, 1'b0, 500, 250, 100);

    ext_run = 1'b1;
    #(60 * CLK_PERIOD);
    expect_state("R2 reselect", 1'b1, 1'b0, 480, 240, 96);

    chk(glitch_r == 0, "R5", "short ref_out pulses", glitch_r, 0);
    chk(glitch_c == 0, "R9", "short ctl_clk pulses", glitch_c, 0);
    finish_run();
  end
endmodule